// File: doc/BRIEF.md
# Arbitrated Memory Request Handshake

This block contains three small controllers that work together: a requester core, a two-way bus arbiter and a memory-side handshake controller. The core takes single-cycle read or write strobes. On a strobe it raises a level-held bus request and waits for its grant. With the grant held, it runs an interlocked exchange with the memory controller. A request is answered by an acknowledge. A read then continues with a data-ready signal from memory, which the core answers with an acknowledge of its own. When the exchange ends, the core drops its bus request and pulses done for one cycle.

A second requester, outside the block, competes for the same bus through a plain request line. The arbiter gives the bus to one requester at a time. It keeps a grant for as long as that request stays high. The acknowledge from memory to the core and the acknowledge from the core to memory are separate wires. Every edge of the exchange comes from a registered controller state, so no combinational path crosses between the three controllers. The memory read data arrives on an input bus and is captured when data-ready rises. The read latency of memory, counted in cycles, is a parameter.

Top module: `bxs_sys`

## Requirements
- R1: While reset is asserted, and right after it, every output is 0: both grants, the bus request, read and write requests, both acknowledges, data-ready, done and read data.
- R2: A read or write strobe that the core samples while idle raises `core_bus_req_o` one clock edge later. If both strobes are high on the same edge, the operation is a read.
- R3: The arbiter raises a requester's grant one edge after it sees that request high, keeps it while the request stays high, and drops it one edge after the request falls. At no time are both grants high.
- R4: If both requests are high at the same edge while no grant is active, the external requester (index 0) wins. The core waits, with no read or write request, until the external request falls. The grant then moves to the core at the very next edge.
- R5: The core raises `rd_req_o` or `wr_req_o` only while `core_gnt_o` is high. It keeps the request until it sees `mem_ack_o` high, then drops it one edge later.
- R6: Memory raises `mem_ack_o` one edge after it sees a read or write request. It keeps the acknowledge while that request is high and drops it one edge after the request falls.
- R7: For a read, `data_rdy_o` rises `RD_LAT` edges after `mem_ack_o` falls, and memory captures `mem_rdata_i` at that edge. It stays high until memory sees `core_ack_o`. The core raises `core_ack_o` one edge after it sees data-ready and keeps it until data-ready falls.
- R8: `done_o` is a single-cycle pulse. It rises at the same edge at which `core_bus_req_o` falls, and `rd_data_o` then holds the captured read data. With the bus free, done rises 6 edges after the strobe edge for a write and 8+`RD_LAT` edges after it for a read.
- R9: Strobes that arrive while the core is busy are ignored. No new bus request follows them after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_rd_i | input | 1 | Read strobe to the core |
| io_wr_i | input | 1 | Write strobe to the core |
| ext_req_i | input | 1 | Bus request from the external requester (level) |
| mem_rdata_i | input | DW | Data presented by the memory array |
| ext_gnt_o | output | 1 | Bus grant to the external requester |
| core_gnt_o | output | 1 | Bus grant to the core |
| core_bus_req_o | output | 1 | Bus request from the core |
| rd_req_o | output | 1 | Read request, core to memory |
| wr_req_o | output | 1 | Write request, core to memory |
| mem_ack_o | output | 1 | Acknowledge, memory to core |
| data_rdy_o | output | 1 | Read data ready, memory to core |
| core_ack_o | output | 1 | Acknowledge of data, core to memory |
| done_o | output | 1 | One-cycle completion pulse to the core |
| rd_data_o | output | DW | Last read data captured by the core |

## Verification
The arbiter can receive the core's bus request and the external request at the same clock edge. To provoke this, the bench strobes a read one edge early, so that the core's request becomes visible at the edge where the external request is first raised. The result is judged by three checks. Only the external grant may appear. The core must keep its bus request and issue no memory request while the external grant is held. The grant must pass to the core at the edge right after the external request falls, and the read must then finish with the expected data. A second coincidence, a read strobe and a write strobe at the same edge, is judged by which memory request appears and by the data returned.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    typedef enum logic [2:0] {
        C_IDLE,
        C_BREQ,
        C_REQ,
        C_WAIT,
        C_RACK
    } core_st_e;

    typedef enum logic [2:0] {
        M_IDLE,
        M_WACK,
        M_RACK,
        M_RWAIT,
        M_RDATA
    } mem_st_e;

endpackage

// File: rtl/bxs_arb.sv
module bxs_arb #(
    parameter int NREQ = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_i,
    output logic [NREQ-1:0] gnt_o
);

    typedef struct packed {
        logic [NREQ-1:0] gnt;
    } arb_reg_t;

    arb_reg_t arb_d, arb_q;
    logic     found;

    always_comb begin
        arb_d = arb_q;
        found = 1'b0;
        // keep the owner while its request stays high, else lowest index wins
        if ((arb_q.gnt & req_i) == '0) begin
            arb_d.gnt = '0;
            for (int i = 0; i < NREQ; i++) begin
                if (!found && req_i[i]) begin
                    arb_d.gnt[i] = 1'b1;
                    found        = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign gnt_o = arb_q.gnt;

endmodule

// File: rtl/bxs_core.sv
module bxs_core
    import bxs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_rd_i,
    input  logic          io_wr_i,
    input  logic          gnt_i,
    input  logic          mem_ack_i,
    input  logic          data_rdy_i,
    input  logic [DW-1:0] mem_data_i,
    output logic          bus_req_o,
    output logic          rd_req_o,
    output logic          wr_req_o,
    output logic          core_ack_o,
    output logic          done_o,
    output logic [DW-1:0] rd_data_o
);

    typedef struct packed {
        core_st_e      st;
        logic          is_rd;
        logic          done;
        logic [DW-1:0] rdata;
    } core_reg_t;

    core_reg_t core_d, core_q;

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        case (core_q.st)
            C_IDLE: begin
                if (io_rd_i || io_wr_i) begin
                    core_d.st    = C_BREQ;
                    core_d.is_rd = io_rd_i;
                end
            end
            C_BREQ: if (gnt_i) core_d.st = C_REQ;
            C_REQ:  if (mem_ack_i) core_d.st = C_WAIT;
            C_WAIT: begin
                if (core_q.is_rd) begin
                    if (data_rdy_i) begin
                        core_d.st    = C_RACK;
                        core_d.rdata = mem_data_i;
                    end
                end else if (!mem_ack_i) begin
                    core_d.st   = C_IDLE;
                    core_d.done = 1'b1;
                end
            end
            C_RACK: begin
                if (!data_rdy_i) begin
                    core_d.st   = C_IDLE;
                    core_d.done = 1'b1;
                end
            end
            default: core_d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '{st: C_IDLE, is_rd: 1'b0, done: 1'b0, rdata: '0};
        else        core_q <= core_d;
    end

    assign bus_req_o  = (core_q.st != C_IDLE);
    assign rd_req_o   = (core_q.st == C_REQ) &&  core_q.is_rd;
    assign wr_req_o   = (core_q.st == C_REQ) && !core_q.is_rd;
    assign core_ack_o = (core_q.st == C_RACK);
    assign done_o     = core_q.done;
    assign rd_data_o  = core_q.rdata;

endmodule

// File: rtl/bxs_mem.sv
module bxs_mem
    import bxs_pkg::*;
#(
    parameter int DW     = 8,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req_i,
    input  logic          wr_req_i,
    input  logic          core_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          mem_ack_o,
    output logic          data_rdy_o,
    output logic [DW-1:0] data_o
);

    localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RD_LAT - 1);

    typedef struct packed {
        mem_st_e       st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
    } mem_reg_t;

    mem_reg_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        case (mem_q.st)
            M_IDLE: begin
                if (wr_req_i)      mem_d.st = M_WACK;
                else if (rd_req_i) mem_d.st = M_RACK;
            end
            M_WACK: if (!wr_req_i) mem_d.st = M_IDLE;
            M_RACK: begin
                if (!rd_req_i) begin
                    mem_d.st  = M_RWAIT;
                    mem_d.cnt = '0;
                end
            end
            M_RWAIT: begin
                if (mem_q.cnt == CNT_LAST) begin
                    mem_d.st   = M_RDATA;
                    mem_d.data = mem_rdata_i;
                end else begin
                    mem_d.cnt = mem_q.cnt + 1'b1;
                end
            end
            M_RDATA: if (core_ack_i) mem_d.st = M_IDLE;
            default: mem_d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '{st: M_IDLE, cnt: '0, data: '0};
        else        mem_q <= mem_d;
    end

    assign mem_ack_o  = (mem_q.st == M_WACK) || (mem_q.st == M_RACK);
    assign data_rdy_o = (mem_q.st == M_RDATA);
    assign data_o     = mem_q.data;

endmodule

// File: rtl/bxs_sys.sv
module bxs_sys #(
    parameter int DW     = 8,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_rd_i,
    input  logic          io_wr_i,
    input  logic          ext_req_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          ext_gnt_o,
    output logic          core_gnt_o,
    output logic          core_bus_req_o,
    output logic          rd_req_o,
    output logic          wr_req_o,
    output logic          mem_ack_o,
    output logic          data_rdy_o,
    output logic          core_ack_o,
    output logic          done_o,
    output logic [DW-1:0] rd_data_o
);

    localparam int NREQ     = 2;
    localparam int IDX_EXT  = 0;
    localparam int IDX_CORE = 1;

    logic [NREQ-1:0] req_vec;
    logic [NREQ-1:0] gnt_vec;
    logic [DW-1:0]   mem_data;

    assign req_vec[IDX_EXT]  = ext_req_i;
    assign req_vec[IDX_CORE] = core_bus_req_o;
    assign ext_gnt_o         = gnt_vec[IDX_EXT];
    assign core_gnt_o        = gnt_vec[IDX_CORE];

    bxs_arb #(.NREQ(NREQ)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_vec),
        .gnt_o (gnt_vec)
    );

    bxs_core #(.DW(DW)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_rd_i    (io_rd_i),
        .io_wr_i    (io_wr_i),
        .gnt_i      (core_gnt_o),
        .mem_ack_i  (mem_ack_o),
        .data_rdy_i (data_rdy_o),
        .mem_data_i (mem_data),
        .bus_req_o  (core_bus_req_o),
        .rd_req_o   (rd_req_o),
        .wr_req_o   (wr_req_o),
        .core_ack_o (core_ack_o),
        .done_o     (done_o),
        .rd_data_o  (rd_data_o)
    );

    bxs_mem #(.DW(DW), .RD_LAT(RD_LAT)) mem_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_i    (rd_req_o),
        .wr_req_i    (wr_req_o),
        .core_ack_i  (core_ack_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_ack_o   (mem_ack_o),
        .data_rdy_o  (data_rdy_o),
        .data_o      (mem_data)
    );

endmodule

// File: rtl/bxs_sys_chk.sv
module bxs_sys_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_req_i,
    input logic ext_gnt_o,
    input logic core_gnt_o,
    input logic core_bus_req_o,
    input logic rd_req_o,
    input logic wr_req_o,
    input logic mem_ack_o,
    input logic data_rdy_o,
    input logic core_ack_o,
    input logic done_o
);

    AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_gnt_o && core_gnt_o)); // R3

    AST_CORE_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        core_gnt_o && core_bus_req_o |=> core_gnt_o); // R3

    AST_EXT_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ext_gnt_o && ext_req_i |=> ext_gnt_o); // R3

    AST_MREQ_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o || wr_req_o) |-> core_gnt_o); // R5

    AST_RDREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !mem_ack_o |=> rd_req_o); // R5

    AST_WRREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !mem_ack_o |=> wr_req_o); // R5

    AST_MACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack_o && (rd_req_o || wr_req_o) |=> mem_ack_o); // R6

    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy_o && !core_ack_o |=> data_rdy_o); // R7

    AST_CACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack_o && data_rdy_o |=> core_ack_o); // R7

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(core_bus_req_o)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

endmodule

bind bxs_sys bxs_sys_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_req_i      (ext_req_i),
    .ext_gnt_o      (ext_gnt_o),
    .core_gnt_o     (core_gnt_o),
    .core_bus_req_o (core_bus_req_o),
    .rd_req_o       (rd_req_o),
    .wr_req_o       (wr_req_o),
    .mem_ack_o      (mem_ack_o),
    .data_rdy_o     (data_rdy_o),
    .core_ack_o     (core_ack_o),
    .done_o         (done_o)
);

// File: tb/bxs_sys_tb_top.sv
module bxs_sys_tb_top;

    localparam int DW     = 8;
    localparam int RD_LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_rd = 1'b0;
    logic          io_wr = 1'b0;
    logic          ext_req = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          ext_gnt, core_gnt, bus_req, rd_req, wr_req;
    logic          mem_ack, data_rdy, core_ack, done;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    logic seen_rd = 1'b0, seen_wr = 1'b0;
    logic p_rd = 1'b0, p_wr = 1'b0, p_ack = 1'b0, p_rdy = 1'b0, p_cack = 1'b0;

    always #10 clk = ~clk;

    bxs_sys #(.DW(DW), .RD_LAT(RD_LAT)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .io_rd_i        (io_rd),
        .io_wr_i        (io_wr),
        .ext_req_i      (ext_req),
        .mem_rdata_i    (mem_rdata),
        .ext_gnt_o      (ext_gnt),
        .core_gnt_o     (core_gnt),
        .core_bus_req_o (bus_req),
        .rd_req_o       (rd_req),
        .wr_req_o       (wr_req),
        .mem_ack_o      (mem_ack),
        .data_rdy_o     (data_rdy),
        .core_ack_o     (core_ack),
        .done_o         (done),
        .rd_data_o      (rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // protocol monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ext_gnt && core_gnt) chk(1'b0, "R3 grant overlap", 2, 1);
            if (p_rd && !rd_req) chk(p_ack, "R5 rd_req fell before ack", p_ack, 1);
            if (p_wr && !wr_req) chk(p_ack, "R5 wr_req fell before ack", p_ack, 1);
            if (p_ack && !mem_ack) chk(!p_rd && !p_wr, "R6 ack fell under request", p_rd | p_wr, 0);
            if (p_rdy && !data_rdy) chk(p_cack, "R7 data_rdy fell before core ack", p_cack, 1);
            if (rd_req) seen_rd = 1'b1;
            if (wr_req) seen_wr = 1'b1;
            p_rd   = rd_req;
            p_wr   = wr_req;
            p_ack  = mem_ack;
            p_rdy  = data_rdy;
            p_cack = core_ack;
        end
    end

    task automatic strobe(input bit r, input bit w);
        @(negedge clk);
        io_rd = r;
        io_wr = w;
        @(posedge clk);
        @(negedge clk);
        io_rd = 1'b0;
        io_wr = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 300) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        if (!done) chk(1'b0, "R8 done never seen", 0, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({ext_gnt, core_gnt, bus_req, rd_req, wr_req, mem_ack, data_rdy, core_ack, done, rd_data} == '0,
            "R1 outputs in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ext_gnt, core_gnt, bus_req, rd_req, wr_req, mem_ack, data_rdy, core_ack, done} == '0,
            "R1 outputs after reset", int'(bus_req), 0);
    endtask

    task automatic t_write();
        int lat;
        seen_rd = 1'b0; seen_wr = 1'b0;
        strobe(1'b0, 1'b1);
        chk(bus_req == 1'b1, "R2 bus request after write strobe", bus_req, 1);
        wait_done(lat);
        chk(lat == 6, "R8 write latency", lat, 6);
        chk(bus_req == 1'b0, "R8 bus released with done", bus_req, 0);
        chk(seen_wr && !seen_rd, "R5 write issues wr_req only", {seen_wr, seen_rd}, 2);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", done, 0);
        chk(core_gnt == 1'b0, "R3 grant dropped after request", core_gnt, 0);
    endtask

    task automatic t_read(input logic [DW-1:0] v);
        int lat;
        seen_rd = 1'b0; seen_wr = 1'b0;
        mem_rdata = v;
        strobe(1'b1, 1'b0);
        wait_done(lat);
        chk(lat == 8 + RD_LAT, "R8 read latency", lat, 8 + RD_LAT);
        chk(rd_data == v, "R7 read data captured", rd_data, v);
        chk(seen_rd && !seen_wr, "R5 read issues rd_req only", {seen_rd, seen_wr}, 2);
        @(negedge clk);
    endtask

    task automatic t_both_strobes();
        int lat;
        seen_rd = 1'b0; seen_wr = 1'b0;
        mem_rdata = 8'h3C;
        strobe(1'b1, 1'b1);
        wait_done(lat);
        chk(seen_rd && !seen_wr, "R2 read wins over write", {seen_rd, seen_wr}, 2);
        chk(rd_data == 8'h3C, "R2 data of winning read", rd_data, 8'h3C);
        @(negedge clk);
    endtask

    task automatic t_busy_ignored();
        int lat;
        bit quiet = 1'b1;
        strobe(1'b0, 1'b1);
        @(negedge clk);
        io_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_rd = 1'b0;
        wait_done(lat);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bus_req) quiet = 1'b0;
        end
        chk(quiet, "R9 strobe while busy ignored", !quiet, 0);
    endtask

    task automatic t_ext_timing();
        @(negedge clk);
        ext_req = 1'b1;
        #1;
        chk(ext_gnt == 1'b0, "R3 no grant before edge", ext_gnt, 0);
        @(posedge clk);
        @(negedge clk);
        chk(ext_gnt == 1'b1, "R3 grant one edge after request", ext_gnt, 1);
        ext_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(ext_gnt == 1'b0, "R3 grant drops one edge after release", ext_gnt, 0);
    endtask

    task automatic t_contention();
        int lat;
        bit held = 1'b1;
        mem_rdata = 8'h96;
        @(negedge clk);
        io_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_rd = 1'b0;
        ext_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(ext_gnt && !core_gnt, "R4 external wins coincident requests", {ext_gnt, core_gnt}, 2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (core_gnt || rd_req || !bus_req) held = 1'b0;
        end
        chk(held, "R4 core waits while external holds bus", !held, 0);
        ext_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(core_gnt && !ext_gnt, "R4 handover at next edge", {ext_gnt, core_gnt}, 1);
        wait_done(lat);
        chk(rd_data == 8'h96, "R4 read after handover", rd_data, 8'h96);
        @(negedge clk);
    endtask

    task automatic t_core_holds();
        int lat;
        bit blocked = 1'b1;
        mem_rdata = 8'h5A;
        strobe(1'b1, 1'b0);
        @(negedge clk);
        ext_req = 1'b1;
        while (!done && lat < 300) begin
            if (ext_gnt) blocked = 1'b0;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk(blocked, "R3 core grant held against external", !blocked, 0);
        chk(rd_data == 8'h5A, "R7 read data under contention", rd_data, 8'h5A);
        @(posedge clk);
        @(negedge clk);
        chk(ext_gnt && !core_gnt, "R3 external granted after core release", {ext_gnt, core_gnt}, 2);
        ext_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_read(8'hA5);
        t_read(8'h0F);
        t_both_strobes();
        t_busy_ignored();
        t_ext_timing();
        t_contention();
        t_core_holds();
        t_write();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule